// File: doc/BRIEF.md
# Minimal Word-Addressed Load-Store Processor Core

A small multicycle processor with one memory port. It fetches 32-bit instructions from a word-addressed memory that also holds its data. Sixteen 32-bit registers feed a datapath that can add, add an immediate, nand two registers, load and store words, branch when two registers are equal, jump and link, and halt. Every instruction takes a fetch cycle and an execute cycle. Loads and stores take one more cycle, in which the port carries the data address.

The core stops fetching after a halt instruction and raises `halted` until reset. The memory is outside the core. Its read path is combinational: `mem_rdata` must show the word at `mem_addr` within the same cycle. A write takes effect at the clock edge on which `mem_we` is high.

Top module: `lsp_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `mem_addr` is 0, `halted` is 0 and `mem_we` is 0. The first instruction is fetched from word 0.
- R2: Register 0 always reads as zero. Any write whose destination is register 0 is discarded.
- R3: Instruction fields are: opcode in bits 31:28, source A in bits 27:24, register B in bits 23:20, destination in bits 3:0, and immediate in bits 19:0. Opcode 0000 writes A+B to the destination. Opcode 0001 writes ~(A&B) to the destination.
- R4: Opcode 0010 writes A plus the sign-extended 20-bit immediate into register B.
- R5: Opcode 0011 loads register B from the memory word at A + sign-extended immediate. Only the low 16 bits of that sum form the address.
- R6: Opcode 0100 stores register B at A + sign-extended immediate. `mem_we` is high for exactly one cycle, and only for this opcode.
- R7: Opcode 0101 sets the PC to PC+1+sign-extended immediate when A equals B, and to PC+1 otherwise.
- R8: Opcode 0110 writes PC+1 into register B and jumps to the address held in A. The jump target is read before the link is written, so A and B may name the same register.
- R9: Opcode 0111 stops fetching and raises `halted`. While halted, `mem_addr` stays at the halt instruction's address and no write occurs, until reset.
- R10: Opcodes 1000 through 1111 change no register and no memory word, and advance the PC by one.
- R11: Each instruction takes 2 cycles, except loads and stores, which take 3. A halt raises `halted` 2 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address for fetch or data access |
| mem_wdata | output | 32 | Data to store |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 32 | Word read from `mem_addr` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions check the port-level rules on every cycle: the reset state, that `halted` stays high with a frozen address and no writes, and that a store strobe never lasts two cycles. Arithmetic results, register-zero behaviour, branch and link targets, load and store addressing, and the no-op opcodes can only be seen through the bench's directed programs. Each program ends by storing its results to memory, and the bench compares those words with values it computes itself. Cycle counts from reset to halt show the per-instruction timing.

// File: rtl/lsp_core.sv
module lsp_core #(
  parameter int XLEN = 32,
  parameter int AW   = 16,
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            halted
);
  localparam int RW   = $clog2(NREG);
  localparam int IMMW = 20;

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_NAND = 4'b0001;
  localparam logic [3:0] OP_ADDI = 4'b0010;
  localparam logic [3:0] OP_LW   = 4'b0011;
  localparam logic [3:0] OP_SW   = 4'b0100;
  localparam logic [3:0] OP_BEQ  = 4'b0101;
  localparam logic [3:0] OP_JALR = 4'b0110;
  localparam logic [3:0] OP_HALT = 4'b0111;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM, S_HALT} st_t;

  st_t             st;
  logic [XLEN-1:0] ir;
  logic [AW-1:0]   pc;
  logic [XLEN-1:0] rf [NREG];

  logic [3:0]      op;
  logic [RW-1:0]   ra, rb, rd;
  logic [XLEN-1:0] simm, va, vb;
  logic [AW-1:0]   pc1, ea;

  assign op   = ir[31:28];
  assign ra   = ir[27:24];
  assign rb   = ir[23:20];
  assign rd   = ir[3:0];
  assign simm = {{(XLEN-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};
  assign va   = (ra == '0) ? '0 : rf[ra];
  assign vb   = (rb == '0) ? '0 : rf[rb];
  assign pc1  = pc + 1'b1;
  assign ea   = va[AW-1:0] + simm[AW-1:0];

  assign mem_addr  = (st == S_MEM) ? ea : pc;
  assign mem_we    = (st == S_MEM) && (op == OP_SW);
  assign mem_wdata = vb;
  assign halted    = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FETCH;
      pc <= '0;
      ir <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          ir <= mem_rdata;
          st <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_FETCH;
          pc <= pc1;
          case (op)
            OP_ADD:  if (rd != '0) rf[rd] <= va + vb;
            OP_NAND: if (rd != '0) rf[rd] <= ~(va & vb);
            OP_ADDI: if (rb != '0) rf[rb] <= va + simm;
            OP_LW, OP_SW: begin
              pc <= pc;
              st <= S_MEM;
            end
            OP_BEQ:  if (va == vb) pc <= pc1 + simm[AW-1:0];
            OP_JALR: begin
              if (rb != '0) rf[rb] <= XLEN'(pc1);
              pc <= va[AW-1:0];
            end
            OP_HALT: begin
              pc <= pc;
              st <= S_HALT;
            end
            default: ;
          endcase
        end
        S_MEM: begin
          if (op == OP_LW && rb != '0) rf[rb] <= mem_rdata;
          pc <= pc1;
          st <= S_FETCH;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lsp_core_chk.sv
module lsp_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          halted
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && !halted && !mem_we));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R9
  halt_addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr));

  // R6
  store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind lsp_core lsp_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we), .halted(halted)
);

// File: tb/sim_lsp_core.sv
module sim_lsp_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [31:0] mem [1024];
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lsp_core u0 (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
               .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted));

  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  function automatic logic [31:0] rt(input logic [3:0] op, ra, rb, rd);
    return {op, ra, rb, 16'h0, rd};
  endfunction
  function automatic logic [31:0] it(input logic [3:0] op, ra, rb, input int imm);
    return {op, ra, rb, imm[19:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEADBEEF;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(output int cyc, output int wcount);
    cyc = 0;
    wcount = 0;
    do_reset();
    while (!halted && cyc < 3000) begin
      if (mem_we) wcount++;
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    if (!halted) chk("R9 program reached halt", {31'b0, halted}, 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 addr in reset", {16'b0, mem_addr}, 32'd0);
    chk("R1 halted in reset", {31'b0, halted}, 32'd0);
    chk("R1 we in reset", {31'b0, mem_we}, 32'd0);
    rst = 1'b0;
    chk("R1 first fetch addr", {16'b0, mem_addr}, 32'd0);
  endtask

  task automatic t_alu();
    int c, w;
    clear_mem();
    mem[0] = it(4'h2, 4'd0, 4'd1, 5);
    mem[1] = it(4'h2, 4'd0, 4'd2, -3);
    mem[2] = rt(4'h0, 4'd1, 4'd2, 4'd3);
    mem[3] = rt(4'h1, 4'd1, 4'd2, 4'd4);
    mem[4] = it(4'h4, 4'd0, 4'd3, 100);
    mem[5] = it(4'h4, 4'd0, 4'd4, 101);
    mem[6] = it(4'h4, 4'd0, 4'd2, 102);
    mem[7] = {4'h7, 28'h0};
    run(c, w);
    chk("R3 add", mem[100], 32'd2);
    chk("R3 nand", mem[101], 32'hFFFFFFFA);
    chk("R4 addi negative imm", mem[102], 32'hFFFFFFFD);
  endtask

  task automatic t_zero();
    int c, w;
    clear_mem();
    mem[0] = it(4'h2, 4'd0, 4'd0, 7);
    mem[1] = it(4'h2, 4'd0, 4'd5, 9);
    mem[2] = rt(4'h0, 4'd5, 4'd5, 4'd0);
    mem[3] = rt(4'h0, 4'd0, 4'd5, 4'd6);
    mem[4] = it(4'h4, 4'd0, 4'd0, 110);
    mem[5] = it(4'h4, 4'd0, 4'd6, 111);
    mem[6] = {4'h7, 28'h0};
    run(c, w);
    chk("R2 r0 stays zero", mem[110], 32'd0);
    chk("R2 r0 reads zero as operand", mem[111], 32'd9);
  endtask

  task automatic t_mem();
    int c, w;
    clear_mem();
    mem[200] = 32'hCAFEF00D;
    mem[0] = it(4'h2, 4'd0, 4'd1, 190);
    mem[1] = it(4'h3, 4'd1, 4'd2, 10);
    mem[2] = it(4'h4, 4'd1, 4'd2, -5);
    mem[3] = {4'h7, 28'h0};
    run(c, w);
    chk("R5 load value", mem[185], 32'hCAFEF00D);
    chk("R6 store count", w, 32'd1);
    chk("R6 neighbour untouched", mem[186], 32'hDEADBEEF);
    // R11: 2 + 3 + 3 + 2 cycles
    chk("R11 cycles to halt", c, 32'd10);
  endtask

  task automatic t_beq();
    int c, w;
    clear_mem();
    mem[0] = it(4'h2, 4'd0, 4'd1, 3);
    mem[1] = it(4'h2, 4'd0, 4'd2, 0);
    mem[2] = it(4'h5, 4'd1, 4'd0, 3);
    mem[3] = it(4'h2, 4'd1, 4'd1, -1);
    mem[4] = it(4'h2, 4'd2, 4'd2, 2);
    mem[5] = it(4'h5, 4'd0, 4'd0, -4);
    mem[6] = it(4'h4, 4'd0, 4'd2, 120);
    mem[7] = {4'h7, 28'h0};
    run(c, w);
    chk("R7 loop taken/not taken", mem[120], 32'd6);
  endtask

  task automatic t_jalr();
    int c, w;
    clear_mem();
    mem[0] = it(4'h2, 4'd0, 4'd1, 5);
    mem[1] = rt(4'h6, 4'd1, 4'd15, 4'd0);
    mem[2] = it(4'h4, 4'd0, 4'd3, 131);
    mem[3] = {4'h7, 28'h0};
    mem[5] = it(4'h2, 4'd0, 4'd3, 44);
    mem[6] = it(4'h4, 4'd0, 4'd15, 130);
    mem[7] = rt(4'h6, 4'd15, 4'd0, 4'd0);
    run(c, w);
    chk("R8 link value", mem[130], 32'd2);
    chk("R8 return path", mem[131], 32'd44);
    clear_mem();
    mem[0] = it(4'h2, 4'd0, 4'd4, 3);
    mem[1] = rt(4'h6, 4'd4, 4'd4, 4'd0);
    mem[2] = {4'h7, 28'h0};
    mem[3] = it(4'h4, 4'd0, 4'd4, 140);
    mem[4] = {4'h7, 28'h0};
    run(c, w);
    chk("R8 same register target and link", mem[140], 32'd2);
  endtask

  task automatic t_nop();
    int c, w;
    clear_mem();
    mem[0] = it(4'h2, 4'd0, 4'd1, 1);
    mem[1] = rt(4'h8, 4'd1, 4'd1, 4'd1);
    mem[2] = it(4'hC, 4'd0, 4'd1, 151);
    mem[3] = it(4'hF, 4'd0, 4'd1, 40);
    mem[4] = it(4'h4, 4'd0, 4'd1, 150);
    mem[5] = {4'h7, 28'h0};
    run(c, w);
    chk("R10 register unchanged", mem[150], 32'd1);
    chk("R10 no store", mem[151], 32'hDEADBEEF);
    chk("R10 single store", w, 32'd1);
  endtask

  task automatic t_halt();
    int c, w;
    clear_mem();
    mem[0] = it(4'h2, 4'd0, 4'd1, 8);
    mem[1] = {4'h7, 28'h0};
    mem[2] = it(4'h4, 4'd0, 4'd1, 160);
    run(c, w);
    // R11: addi 2 cycles + halt 2 cycles
    chk("R11 halt timing", c, 32'd4);
    repeat (20) begin
      @(posedge clk);
      @(negedge clk);
      if (mem_we) w++;
    end
    chk("R9 halted held", {31'b0, halted}, 32'd1);
    chk("R9 addr held at halt", {16'b0, mem_addr}, 32'd1);
    chk("R9 no writes while halted", w, 32'd0);
    chk("R9 no fetch past halt", mem[160], 32'hDEADBEEF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clear_mem();
    t_reset();
    t_alu();
    t_zero();
    t_mem();
    t_beq();
    t_jalr();
    t_nop();
    t_halt();
    t_reset();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule